// File: doc/BRIEF.md
# Core Clock-Control Power State Machine

This block follows the clock-control state of a processor core and drives the enable that lets the internal core clock run. It runs on an always-on reference clock. Several events move it between states: a strobe marking a retired halt instruction, an active-low stop-clock request, an inquire (snoop) request with its completion flag, interrupt and soft-reset events, and writes into a 16-byte power-management register window. It also watches the external bus clock, and it treats that clock as stopped once no edge has arrived for a set number of reference cycles.

The core clock is enabled only in the Normal state. When a stop-clock request is accepted, the block raises a one-cycle acknowledge. The parameter `LOW_POWER` selects the variant. With `LOW_POWER=1` the block has a sixth state: a timed stop-grant, entered by writing a non-zero count into a timeout field. With `LOW_POWER=0` the block has five states and writes to that field do nothing.

Top module: `coreClkPwrCtl`

## Requirements
- R1: While `rstN` is low and after it is released, `pwrState` is 0 (Normal), `coreClkEn` is 1 and `stopGrantAck` is 0. Pulling `rstN` low in any state returns the block to Normal at once.
- R2: `pwrState` uses this encoding: 0 Normal, 1 Halt, 2 Stop Grant, 3 Inquire, 4 Stop Clock, 5 Timed Stop Grant. `coreClkEn` is 1 exactly when `pwrState` is 0, and it changes on the same clock edge as `pwrState`.
- R3: In Normal, a high `haltDone` moves the block to Halt on the next edge. In Halt, a high `intrEvt` returns it to Normal. If `intrEvt` and `inqReq` are high in the same cycle, `intrEvt` wins.
- R4: `stopClkN` low in Normal or Halt moves the block to Stop Grant, and it wins over a `haltDone` in the same cycle. When `stopClkN` goes high in Stop Grant, the block returns to Normal.
- R5: `inqReq` moves the block from Halt or from Stop Grant to Inquire. A later `inqDone` returns it to the state it came from.
- R6: After the block enters Stop Grant from Normal or Halt, `stopGrantAck` is high for exactly one cycle, starting one cycle after `pwrState` becomes 2. A return to Stop Grant from Inquire or from Stop Clock gives no pulse.
- R7: In Stop Grant, if `busClk` shows no edge for `BUS_IDLE_CYCLES` reference cycles, the block moves to Stop Clock. It does not move one cycle earlier. The first `busClk` edge after that returns the block to Stop Grant two cycles later.
- R8: With `LOW_POWER=1`, a write in Normal of a non-zero value N to offset `TMO_OFFSET` (2) of the register window enters Timed Stop Grant. The block stays there for N cycles and then returns to Normal. A write of zero, a write to another offset, and any write made while the block is in Timed Stop Grant all have no effect.
- R9: With `LOW_POWER=0`, a non-zero write to the timeout field leaves the block in Normal. State 5 is never reached.
- R10: A high `resetEvt` returns the block to Normal from any state on the next edge. It wins over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busClk | input | 1 | External bus clock, sampled as a level |
| haltDone | input | 1 | Halt instruction retired (strobe) |
| stopClkN | input | 1 | Stop-clock request, active low |
| inqReq | input | 1 | Inquire cycle request |
| inqDone | input | 1 | Inquire cycle complete |
| intrEvt | input | 1 | Interrupt event |
| resetEvt | input | 1 | Soft reset event, forces Normal |
| regWrEn | input | 1 | Register window write strobe |
| regAddr | input | ADDR_W | Byte offset within the register window |
| regWrData | input | CNT_W | Write data (timeout count) |
| pwrState | output | 3 | Current clock-control state |
| coreClkEn | output | 1 | Internal core clock enable |
| stopGrantAck | output | 1 | Stop-grant acknowledge pulse |

## Verification
The case to watch is two transition sources firing in the same cycle. The bench provokes it in three ways: a halt strobe arrives together with a stop-clock request in Normal, an interrupt arrives together with an inquire request in Halt, and a soft-reset event arrives while a stop-clock request is held. Each case is judged by the state sampled after the edge, which must show that the stop request, the interrupt and the reset event win respectively. A timeout rewrite made during a timed stop-grant must also leave the cycle on which the block returns to Normal unchanged.

// File: rtl/pwrPkg.sv
package pwrPkg;

  typedef enum logic [2:0] {
    PS_NORMAL  = 3'd0,
    PS_HALT    = 3'd1,
    PS_STOPGNT = 3'd2,
    PS_INQUIRE = 3'd3,
    PS_STOPCLK = 3'd4,
    PS_TIMED   = 3'd5
  } pwrState_t;

  typedef struct packed {
    logic loadTmo;
    logic decTmo;
    logic setOrigin;
    logic originSg;
    logic sgEnter;
  } ctlStrobe_t;

endpackage

// File: rtl/pwrDatapath.sv
module pwrDatapath
  import pwrPkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int ADDR_W      = 4,
  parameter int TMO_OFFSET  = 2,
  parameter int IDLE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busClk,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  input  ctlStrobe_t        strb,
  output logic              busStopped,
  output logic              tmoWrNz,
  output logic              tmoLast,
  output logic              originSg,
  output logic              stopGrantAck
);

  localparam int IDLE_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(IDLE_CYCLES);
  localparam logic [ADDR_W-1:0] TMO_ADDR = ADDR_W'(TMO_OFFSET);

  logic              busQ;
  logic [IDLE_W-1:0] idleCnt;
  logic [CNT_W-1:0]  tmoCnt;
  logic              sgPend;

  // Bus clock activity watch: any level change clears the idle count.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busQ    <= 1'b0;
      idleCnt <= '0;
    end else begin
      busQ <= busClk;
      if (busClk != busQ)
        idleCnt <= '0;
      else if (idleCnt != IDLE_LIM)
        idleCnt <= idleCnt + 1'b1;
    end
  end

  assign busStopped = (idleCnt == IDLE_LIM);

  // Timed stop-grant down-counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      tmoCnt <= '0;
    else if (strb.loadTmo)
      tmoCnt <= regWrData;
    else if (strb.decTmo)
      tmoCnt <= tmoCnt - 1'b1;
  end

  assign tmoWrNz = regWrEn && (regAddr == TMO_ADDR) && (|regWrData);
  assign tmoLast = (tmoCnt == CNT_W'(1));

  // Origin of an inquire excursion, and the delayed acknowledge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      originSg     <= 1'b0;
      sgPend       <= 1'b0;
      stopGrantAck <= 1'b0;
    end else begin
      if (strb.setOrigin)
        originSg <= strb.originSg;
      sgPend       <= strb.sgEnter;
      stopGrantAck <= sgPend;
    end
  end

endmodule

// File: rtl/pwrControl.sv
module pwrControl
  import pwrPkg::*;
#(
  parameter int LOW_POWER = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       haltDone,
  input  logic       stopClkN,
  input  logic       inqReq,
  input  logic       inqDone,
  input  logic       intrEvt,
  input  logic       resetEvt,
  input  logic       busStopped,
  input  logic       tmoWrNz,
  input  logic       tmoLast,
  input  logic       originIn,
  output pwrState_t  state,
  output logic       coreClkEn,
  output ctlStrobe_t strb
);

  localparam bit HAS_TIMED = (LOW_POWER != 0);

  pwrState_t nxt;

  always_comb begin
    nxt  = state;
    strb = '0;
    if (resetEvt) begin
      nxt = PS_NORMAL;
    end else begin
      case (state)
        PS_NORMAL: begin
          if (!stopClkN) begin
            nxt          = PS_STOPGNT;
            strb.sgEnter = 1'b1;
          end else if (haltDone) begin
            nxt = PS_HALT;
          end else if (HAS_TIMED && tmoWrNz) begin
            nxt          = PS_TIMED;
            strb.loadTmo = 1'b1;
          end
        end
        PS_HALT: begin
          if (intrEvt) begin
            nxt = PS_NORMAL;
          end else if (!stopClkN) begin
            nxt          = PS_STOPGNT;
            strb.sgEnter = 1'b1;
          end else if (inqReq) begin
            nxt            = PS_INQUIRE;
            strb.setOrigin = 1'b1;
            strb.originSg  = 1'b0;
          end
        end
        PS_STOPGNT: begin
          if (stopClkN) begin
            nxt = PS_NORMAL;
          end else if (inqReq) begin
            nxt            = PS_INQUIRE;
            strb.setOrigin = 1'b1;
            strb.originSg  = 1'b1;
          end else if (busStopped) begin
            nxt = PS_STOPCLK;
          end
        end
        PS_INQUIRE: begin
          if (inqDone)
            nxt = originIn ? PS_STOPGNT : PS_HALT;
        end
        PS_STOPCLK: begin
          if (!busStopped)
            nxt = PS_STOPGNT;
        end
        PS_TIMED: begin
          strb.decTmo = 1'b1;
          if (tmoLast)
            nxt = PS_NORMAL;
        end
        default: nxt = PS_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= PS_NORMAL;
      coreClkEn <= 1'b1;
    end else begin
      state     <= nxt;
      coreClkEn <= (nxt == PS_NORMAL);
    end
  end

endmodule

// File: rtl/coreClkPwrCtl.sv
module coreClkPwrCtl
  import pwrPkg::*;
#(
  parameter int LOW_POWER       = 1,
  parameter int CNT_W           = 8,
  parameter int ADDR_W          = 4,
  parameter int TMO_OFFSET      = 2,
  parameter int BUS_IDLE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busClk,
  input  logic              haltDone,
  input  logic              stopClkN,
  input  logic              inqReq,
  input  logic              inqDone,
  input  logic              intrEvt,
  input  logic              resetEvt,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [2:0]        pwrState,
  output logic              coreClkEn,
  output logic              stopGrantAck
);

  ctlStrobe_t strb;
  pwrState_t  curState;
  logic       busStopped;
  logic       tmoWrNz;
  logic       tmoLast;
  logic       originSg;

  pwrControl #(.LOW_POWER(LOW_POWER)) uCtl (
    .clk(clk), .rstN(rstN),
    .haltDone(haltDone), .stopClkN(stopClkN),
    .inqReq(inqReq), .inqDone(inqDone),
    .intrEvt(intrEvt), .resetEvt(resetEvt),
    .busStopped(busStopped), .tmoWrNz(tmoWrNz),
    .tmoLast(tmoLast), .originIn(originSg),
    .state(curState), .coreClkEn(coreClkEn), .strb(strb)
  );

  pwrDatapath #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W),
    .TMO_OFFSET(TMO_OFFSET), .IDLE_CYCLES(BUS_IDLE_CYCLES)
  ) uDp (
    .clk(clk), .rstN(rstN), .busClk(busClk),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .strb(strb), .busStopped(busStopped), .tmoWrNz(tmoWrNz),
    .tmoLast(tmoLast), .originSg(originSg), .stopGrantAck(stopGrantAck)
  );

  assign pwrState = curState;

endmodule

// File: rtl/coreClkPwrCtl_chk.sv
module coreClkPwrCtl_chk
  import pwrPkg::*;
#(
  parameter int LOW_POWER = 1
) (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] pwrState,
  input logic       coreClkEn,
  input logic       stopGrantAck
);

  AST_EN_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    coreClkEn == (pwrState == PS_NORMAL)); // R2

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    pwrState <= PS_TIMED); // R2

  AST_ACK_FOLLOWS_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PS_STOPGNT &&
     ($past(pwrState) == PS_NORMAL || $past(pwrState) == PS_HALT))
    |=> stopGrantAck); // R6

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    stopGrantAck |=> !stopGrantAck); // R6

  AST_STOPCLK_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PS_STOPCLK && $past(pwrState) != PS_STOPCLK)
    |-> $past(pwrState) == PS_STOPGNT); // R7

  AST_INQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PS_INQUIRE && $past(pwrState) != PS_INQUIRE)
    |-> ($past(pwrState) == PS_HALT || $past(pwrState) == PS_STOPGNT)); // R5

  AST_NO_TIMED_STD: assert property (@(posedge clk) disable iff (!rstN)
    (LOW_POWER == 0) |-> pwrState != PS_TIMED); // R9

endmodule

bind coreClkPwrCtl coreClkPwrCtl_chk #(.LOW_POWER(LOW_POWER)) uChk (
  .clk(clk), .rstN(rstN), .pwrState(pwrState),
  .coreClkEn(coreClkEn), .stopGrantAck(stopGrantAck)
);

// File: tb/coreClkPwrCtl_test.sv
module coreClkPwrCtl_test;

  localparam int IDLE = 8;
  localparam int NVEC = 17;

  // {haltDone, stopClkN, inqReq, inqDone, intrEvt, resetEvt, expState[2:0], expEn}
  localparam logic [9:0] VEC [NVEC] = '{
    10'b1_1_0_0_0_0_001_0, // R3 Normal -> Halt
    10'b0_1_0_0_0_0_001_0, // R3 Halt holds
    10'b0_1_1_0_0_0_011_0, // R5 Halt -> Inquire
    10'b0_1_0_1_0_0_001_0, // R5 back to Halt
    10'b0_1_0_0_1_0_000_1, // R3 interrupt -> Normal
    10'b0_0_0_0_0_0_010_0, // R4 Normal -> Stop Grant
    10'b0_0_1_0_0_0_011_0, // R5 Stop Grant -> Inquire
    10'b0_0_0_1_0_0_010_0, // R5 back to Stop Grant
    10'b0_1_0_0_0_0_000_1, // R4 release -> Normal
    10'b1_0_0_0_0_0_010_0, // R4 stop beats halt
    10'b0_1_0_0_0_0_000_1, // R4 release
    10'b1_1_0_0_0_0_001_0, // R3 Halt
    10'b0_0_0_0_0_0_010_0, // R4 Halt -> Stop Grant
    10'b0_0_0_0_0_1_000_1, // R10 reset event wins
    10'b1_1_0_0_0_0_001_0, // R3 Halt
    10'b0_1_1_0_1_0_000_1, // R3 interrupt beats inquire
    10'b0_1_0_0_0_0_000_1  // R2 Normal holds
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busClk = 1'b0;
  logic       busRun = 1'b1;
  logic       haltDone = 1'b0, stopClkN = 1'b1, inqReq = 1'b0, inqDone = 1'b0;
  logic       intrEvt = 1'b0, resetEvt = 1'b0, regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [2:0] pwrState, stdState;
  logic       coreClkEn, stopGrantAck, stdEn, stdAck;
  int         nChecks = 0;
  int         nFails = 0;

  always #4 clk = ~clk;

  coreClkPwrCtl #(.LOW_POWER(1), .BUS_IDLE_CYCLES(IDLE)) uut (
    .clk(clk), .rstN(rstN), .busClk(busClk), .haltDone(haltDone),
    .stopClkN(stopClkN), .inqReq(inqReq), .inqDone(inqDone),
    .intrEvt(intrEvt), .resetEvt(resetEvt), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .pwrState(pwrState),
    .coreClkEn(coreClkEn), .stopGrantAck(stopGrantAck)
  );

  coreClkPwrCtl #(.LOW_POWER(0), .BUS_IDLE_CYCLES(IDLE)) uutStd (
    .clk(clk), .rstN(rstN), .busClk(busClk), .haltDone(haltDone),
    .stopClkN(stopClkN), .inqReq(inqReq), .inqDone(inqDone),
    .intrEvt(intrEvt), .resetEvt(resetEvt), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .pwrState(stdState),
    .coreClkEn(stdEn), .stopGrantAck(stdAck)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    if (busRun) busClk = ~busClk;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearIn();
    haltDone = 1'b0; inqReq = 1'b0; inqDone = 1'b0;
    intrEvt = 1'b0; resetEvt = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 state in reset", pwrState, 0);
    check("R1 enable in reset", coreClkEn, 1);
    rstN = 1'b1;
    step();
    check("R1 state after reset", pwrState, 0);
    check("R1 enable after reset", coreClkEn, 1);
    check("R1 ack after reset", stopGrantAck, 0);

    // Vector table: R2 R3 R4 R5 R10
    for (int i = 0; i < NVEC; i++) begin
      haltDone = VEC[i][9]; stopClkN = VEC[i][8]; inqReq = VEC[i][7];
      inqDone = VEC[i][6]; intrEvt = VEC[i][5]; resetEvt = VEC[i][4];
      step();
      check($sformatf("R2 R3 R4 R5 R10 vector %0d state", i), pwrState, int'(VEC[i][3:1]));
      check($sformatf("R2 vector %0d enable", i), coreClkEn, int'(VEC[i][0]));
    end
    clearIn();
    stopClkN = 1'b1;
    step();

    // R6 acknowledge timing
    stopClkN = 1'b0;
    step();
    check("R6 state Stop Grant", pwrState, 2);
    check("R6 ack not yet", stopGrantAck, 0);
    step();
    check("R6 ack pulse", stopGrantAck, 1);
    step();
    check("R6 ack ends", stopGrantAck, 0);

    // R7 bus clock stop and resume
    busRun = 1'b0;
    repeat (IDLE) step();
    check("R7 still Stop Grant at limit", pwrState, 2);
    step();
    check("R7 Stop Clock", pwrState, 4);
    check("R7 enable off", coreClkEn, 0);
    busRun = 1'b1;
    step();
    check("R7 Stop Clock one cycle after edge", pwrState, 4);
    step();
    check("R7 back to Stop Grant", pwrState, 2);
    check("R6 no ack on return from Stop Clock", stopGrantAck, 0);
    step();
    check("R6 still no ack", stopGrantAck, 0);
    stopClkN = 1'b1;
    step();
    check("R4 release from Stop Grant", pwrState, 0);

    // R8 timed stop grant, R9 standard variant
    regWrite(4'd2, 8'd0);
    step();
    check("R8 zero write ignored", pwrState, 0);
    regWrite(4'd3, 8'd5);
    step();
    check("R8 other offset ignored", pwrState, 0);
    regWrite(4'd2, 8'd4);
    step();
    check("R8 enter timed", pwrState, 5);
    check("R8 enable off", coreClkEn, 0);
    check("R9 standard stays Normal", stdState, 0);
    check("R9 standard enable", stdEn, 1);
    clearIn();
    step();
    check("R8 timed cycle 2", pwrState, 5);
    regWrite(4'd2, 8'd200);
    step();
    check("R8 rewrite ignored cycle 3", pwrState, 5);
    clearIn();
    step();
    check("R8 timed cycle 4", pwrState, 5);
    step();
    check("R8 return Normal", pwrState, 0);
    check("R8 enable back", coreClkEn, 1);
    check("R9 standard never timed", stdState, 0);

    // R1 asynchronous reset mid-operation
    haltDone = 1'b1;
    step();
    clearIn();
    check("R3 Halt before reset", pwrState, 1);
    #2 rstN = 1'b0;
    #1;
    check("R1 async reset state", pwrState, 0);
    check("R1 async reset enable", coreClkEn, 1);
    @(negedge clk);
    rstN = 1'b1;
    step();

    summary();
    $finish;
  end

endmodule